// File: doc/BRIEF.md
# Clock-Compensated Beep Tone Generator

This block produces a square-wave beep from one bit of a free-running counter that advances once every two system clocks. Software picks the pitch by setting one bit in a nine-bit tap field. It starts and stops the tone through a separate enable bit. The output is a single registered logic level, meant to drive an external audio stage.

The system clock can be slowed to one half or one thirty-second of its full rate. When that happens, the counter slows down with it. To keep the pitch the same, the generator reads the current frequency mode and drops its tap by the matching number of bit positions. Software never has to reprogram the field when the clock rate changes.

Top module: `tone_gen`

## Requirements
- R1: After synchronous reset, `beep_o` is low, the enable reads 0 and the tap field reads 0.
- R2: Writes to the control register (`addr`=0) keep only bit 0, which is the enable. Writes to the tap register (`addr`=1) keep only bits 18:10. Every other bit reads back as 0.
- R3: The counter advances once every two clocks. With the tap field set to bit 10, full mode, and enable set, `beep_o` changes level every 2048 clocks.
- R4: With tap field position i (counter bit 10+i) in full mode, `beep_o` changes level every 2^(11+i) clocks.
- R5: With `freq_mode`=2'b01 (half rate), the tap used is one position below the programmed one.
- R6: With `freq_mode`=2'b10 (one thirty-second rate), the tap used is five positions below the programmed one.
- R7: When the lowered position would fall below field position 0, it saturates at field position 0 (counter bit 10).
- R8: If more than one bit of the tap field is set, the lowest set bit is used.
- R9: If the tap field is zero, `beep_o` stays low.
- R10: While the enable is 0, `beep_o` stays low.
- R11: `freq_mode`=2'b11 behaves the same as full mode (2'b00), with no shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 = control, 1 = tap |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for the register selected by `addr` (combinational) |
| freq_mode | input | 2 | Current system clock rate: 00 full, 01 half, 10 one thirty-second, 11 treated as full |
| beep_o | output | 1 | Registered beep square wave |

## Verification
The hardest case to reach from the ports is the compensation path. The clock in the bench never slows, so the compensation shows up only as a change in the measured half-period when `freq_mode` changes.

The stimulus programs a higher tap together with a reduced-rate mode. It then checks that the edge-to-edge spacing matches the spacing of the lower tap the requirement names. Saturation is reached by combining a low tap with the one thirty-second mode. Multi-bit fields are used so that choosing the highest set bit instead of the lowest would give a different spacing.

// File: rtl/tone_pkg.sv
package tone_pkg;

    localparam int unsigned REG_W   = 32;
    localparam int unsigned TAP_LSB = 10;
    localparam int unsigned TAP_W   = 9;

    typedef enum logic [1:0] {
        FM_FULL = 2'b00,
        FM_HALF = 2'b01,
        FM_SLOW = 2'b10,
        FM_RSVD = 2'b11
    } freq_mode_e;

    typedef enum logic {
        REG_CTRL = 1'b0,
        REG_TAP  = 1'b1
    } reg_sel_e;

    // Number of tap positions to drop for a given clock rate
    function automatic int unsigned tap_shift(freq_mode_e m);
        case (m)
            FM_HALF: return 1;
            FM_SLOW: return 5;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/tone_regs.sv
module tone_regs
    import tone_pkg::*;
#(
    parameter int unsigned DATA_W = REG_W,
    parameter int unsigned FLD_LSB = TAP_LSB,
    parameter int unsigned FLD_W = TAP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              beep_en,
    output logic [FLD_W-1:0]  tap_field
);

    logic             en_q;
    logic [FLD_W-1:0] tap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            tap_q <= '0;
        end else if (wr_en) begin
            if (reg_sel_e'(addr) == REG_CTRL) en_q  <= wdata[0];
            else                              tap_q <= wdata[FLD_LSB +: FLD_W];
        end
    end

    always_comb begin
        rd_data = '0;
        if (reg_sel_e'(addr) == REG_CTRL) rd_data[0] = en_q;
        else                              rd_data[FLD_LSB +: FLD_W] = tap_q;
    end

    assign beep_en   = en_q;
    assign tap_field = tap_q;

endmodule

// File: rtl/tone_counter.sv
module tone_counter #(
    parameter int unsigned CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_val
);

    logic             phase_q;
    logic [CNT_W-1:0] cnt_q;

    // The counter advances once every two system clocks
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            phase_q <= ~phase_q;
            if (phase_q) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_val = cnt_q;

endmodule

// File: rtl/tone_tap_sel.sv
module tone_tap_sel
    import tone_pkg::*;
#(
    parameter int unsigned FLD_LSB = TAP_LSB,
    parameter int unsigned FLD_W = TAP_W,
    localparam int unsigned CNT_W = FLD_LSB + FLD_W,
    localparam int unsigned IDX_W = $clog2(CNT_W)
) (
    input  logic [FLD_W-1:0] tap_field,
    input  logic [1:0]       freq_mode,
    output logic             tap_valid,
    output logic [IDX_W-1:0] sel_bit
);

    int unsigned low_idx;
    int unsigned shift;
    int unsigned eff_idx;

    always_comb begin
        // Scan from the top so the lowest set bit is the one kept
        low_idx = 0;
        for (int i = FLD_W - 1; i >= 0; i--) begin
            if (tap_field[i]) low_idx = i;
        end
        shift   = tap_shift(freq_mode_e'(freq_mode));
        eff_idx = (low_idx >= shift) ? (low_idx - shift) : 0;
        sel_bit = IDX_W'(FLD_LSB + eff_idx);
        tap_valid = |tap_field;
    end

endmodule

// File: rtl/tone_gen.sv
module tone_gen
    import tone_pkg::*;
#(
    parameter int unsigned DATA_W = REG_W,
    parameter int unsigned FLD_LSB = TAP_LSB,
    parameter int unsigned FLD_W = TAP_W,
    localparam int unsigned CNT_W = FLD_LSB + FLD_W,
    localparam int unsigned IDX_W = $clog2(CNT_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    input  logic [1:0]        freq_mode,
    output logic              beep_o
);

    logic             beep_en;
    logic [FLD_W-1:0] tap_field;
    logic [CNT_W-1:0] cnt_val;
    logic             tap_valid;
    logic [IDX_W-1:0] sel_bit;
    logic             beep_q;

    tone_regs #(.DATA_W(DATA_W), .FLD_LSB(FLD_LSB), .FLD_W(FLD_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rd_data  (rd_data),
        .beep_en  (beep_en),
        .tap_field(tap_field)
    );

    tone_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .cnt_val(cnt_val)
    );

    tone_tap_sel #(.FLD_LSB(FLD_LSB), .FLD_W(FLD_W)) u_sel (
        .tap_field(tap_field),
        .freq_mode(freq_mode),
        .tap_valid(tap_valid),
        .sel_bit  (sel_bit)
    );

    // The output is registered so that a tap change cannot glitch it
    always_ff @(posedge clk) begin
        if (rst) beep_q <= 1'b0;
        else     beep_q <= beep_en & tap_valid & cnt_val[sel_bit];
    end

    assign beep_o = beep_q;

endmodule

// File: rtl/tone_gen_chk.sv
module tone_gen_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned FLD_LSB = 10,
    parameter int unsigned FLD_W = 9,
    localparam int unsigned CNT_W = FLD_LSB + FLD_W
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] rd_data,
    input logic              beep_o,
    input logic              beep_en,
    input logic [FLD_W-1:0]  tap_field,
    input logic [CNT_W-1:0]  cnt_val
);

    localparam logic [DATA_W-1:0] LIVE_MASK =
        (((DATA_W'(1) << FLD_W) - 1'b1) << FLD_LSB) | DATA_W'(1);

    logic rst_d = 1'b0;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: the cycle after reset is held, the output is low
    always @(negedge clk) begin
        if (rst_d) a_r1_reset_quiet: assert (!beep_o);
    end

    // R2: bits outside the stored fields always read back as zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~LIVE_MASK) == '0);

    // R3: the counter never advances on two cycles in a row
    a_r3_half_rate: assert property (@(posedge clk) disable iff (rst)
        (cnt_val != $past(cnt_val)) |=> (cnt_val == $past(cnt_val)));

    // R9: an empty tap field silences the output
    a_r9_empty_tap_low: assert property (@(posedge clk) disable iff (rst)
        (tap_field == '0) |=> !beep_o);

    // R10: a cleared enable silences the output
    a_r10_disabled_low: assert property (@(posedge clk) disable iff (rst)
        !beep_en |=> !beep_o);

endmodule

bind tone_gen tone_gen_chk #(.DATA_W(DATA_W), .FLD_LSB(FLD_LSB), .FLD_W(FLD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_data  (rd_data),
    .beep_o   (beep_o),
    .beep_en  (beep_en),
    .tap_field(tap_field),
    .cnt_val  (cnt_val)
);

// File: tb/test_tone_gen.sv
module test_tone_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        addr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic [1:0]  freq_mode = 2'b00;
    logic        beep_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    tone_gen i_tone_gen (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rd_data  (rd_data),
        .freq_mode(freq_mode),
        .beep_o   (beep_o)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected=<190000", cycles);
            summary();
        end
    end

    task automatic check(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(logic a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(logic a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    // Skip to one edge of beep_o, then count clocks up to the next edge
    task automatic half_period(output int n);
        logic prev;
        int   guard;
        n = 0;
        @(negedge clk); prev = beep_o; guard = 0;
        while (beep_o == prev && guard < 40000) begin @(negedge clk); guard++; end
        prev = beep_o;
        while (n < 40000) begin
            @(negedge clk); n++;
            if (beep_o != prev) break;
        end
    endtask

    task automatic stays_low(int len, output int highs);
        highs = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (beep_o) highs++;
        end
    endtask

    function automatic logic [31:0] tap(int idx);
        return 32'h1 << (10 + idx);
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        check("R1 beep", beep_o, 0);
        read_reg(1'b0, d); check("R1 enable", d, 0);
        read_reg(1'b1, d); check("R1 tap", d, 0);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        write_reg(1'b0, 32'hFFFF_FFFF);
        write_reg(1'b1, 32'hFFFF_FFFF);
        read_reg(1'b0, d); check("R2 ctrl", d, 32'h1);
        read_reg(1'b1, d); check("R2 tap", d, 32'h0007_FC00);
        write_reg(1'b0, 32'hFFFF_FFFE);
        read_reg(1'b0, d); check("R2 ctrl clear", d, 32'h0);
    endtask

    task automatic t_period(string req, logic [31:0] t, logic [1:0] m, int exp);
        int n;
        freq_mode = m;
        write_reg(1'b1, t);
        write_reg(1'b0, 32'h1);
        half_period(n);
        check(req, n, exp);
    endtask

    task automatic t_quiet();
        int h;
        write_reg(1'b0, 32'h1);
        write_reg(1'b1, 32'h0);
        stays_low(5000, h);
        check("R9 zero tap", h, 0);
        write_reg(1'b1, tap(0));
        write_reg(1'b0, 32'h0);
        @(negedge clk);
        stays_low(5000, h);
        check("R10 disabled", h, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_reserved();
        t_period("R3 bit10 full", tap(0), 2'b00, 2048);
        t_period("R4 bit12 full", tap(2), 2'b00, 8192);
        t_period("R4 bit11 full", tap(1), 2'b00, 4096);
        t_period("R5 half rate", tap(1), 2'b01, 2048);
        t_period("R5 half rate bit13", tap(3), 2'b01, 8192);
        t_period("R6 slow rate", tap(5), 2'b10, 2048);
        t_period("R7 saturation", tap(2), 2'b10, 2048);
        t_period("R8 lowest bit", tap(1) | tap(2), 2'b00, 4096);
        t_period("R11 mode 3", tap(1), 2'b11, 4096);
        t_quiet();
        summary();
    end

endmodule